// File: doc/BRIEF.md
# Set-Associative Cache Lookup Controller

This controller keeps the valid bits, tags and data of a small cache. One parameter, the number of ways, selects the organisation. One way gives a direct-mapped cache. Setting the number of ways equal to the number of lines gives a fully associative cache, and any value in between gives an N-way set-associative cache. Each request carries a memory line number. The controller derives the set from it and compares the tag against the indexed line of every way in parallel. It then reports whether the request hit and, if so, in which way and at which physical cache line.

A read that hits returns its data at once. A read that misses in every way is sent out on a lower-level port with a valid/ready handshake. The controller waits for the response strobe, installs the returned data and then answers. While that miss is outstanding it accepts no new request. A write that hits updates the hitting way. A write that misses takes its way from an external victim selector, which sees the set index on `vic_set` and answers on `vic_way`. The same selector also picks the way for a read fill. The selector must always present a way number below the number of ways.

Top module: `sac_lookup`

## Requirements
- R1: The set of a request is its line number modulo SETS, where SETS = NUM_LINES / NUM_WAYS. The stored tag is the line number divided by SETS. Two lines in the same set with different tags are told apart.
- R2: Way w of set s is physical cache line w*SETS + s, and `rsp_line` reports it. With 8 lines in 2 ways, line 9 is probed at physical lines 1 and 5.
- R3: A way misses when its line is invalid or when its tag differs from the request's tag. At most one way hits.
- R4: A read hit gives `rsp_valid`=1, `rsp_hit`=1, the hit way and the stored data in the cycle after acceptance. No lower-level request is raised.
- R5: A read miss raises `low_req_valid` with `low_req_line` equal to the request line in the cycle after acceptance. Both are held until `low_req_ready`. On `low_rsp_valid`, `low_rsp_data` is written into way `vic_way` of the set. In the next cycle the controller answers with `rsp_hit`=0, that way and that data.
- R6: `req_ready` is 0 from the cycle after a read miss is accepted until the cycle after the fill, and 1 otherwise.
- R7: A write hit overwrites the data of the hit way, ignores `vic_way`, and answers with `rsp_hit`=1 in the next cycle.
- R8: A write miss installs the tag, the valid bit and the data in way `vic_way` of the set. It answers with `rsp_hit`=0 and that way in the next cycle.
- R9: Reset clears every valid bit, leaves `req_ready`=1, and drives `rsp_valid` and `low_req_valid` to 0. The first read after reset misses.
- R10: With NUM_WAYS = NUM_LINES there is one set, and lines that would share a set under fewer ways are all held at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | LINE_W | Memory line number |
| req_wdata | input | DATA_W | Write data |
| vic_set | output | SET_W | Set for which a victim is being chosen |
| vic_way | input | WAY_W | Way chosen by the victim selector |
| low_req_valid | output | 1 | Read miss forwarded downstream |
| low_req_ready | input | 1 | Lower level accepts the forwarded request |
| low_req_line | output | LINE_W | Line number of the forwarded read |
| low_rsp_valid | input | 1 | Fill data strobe from the lower level |
| low_rsp_data | input | DATA_W | Fill data |
| rsp_valid | output | 1 | Answer strobe, one per request |
| rsp_write | output | 1 | Answer belongs to a write |
| rsp_hit | output | 1 | Request hit in the cache |
| rsp_way | output | WAY_W | Way hit or filled |
| rsp_line | output | PHYS_W | Physical cache line used |
| rsp_data | output | DATA_W | Read data, fill data or written data |

## Verification
Hits and write misses answer exactly one cycle after the acceptance edge. The bench drives each request at a falling edge and reads the answer at the next falling edge. A read miss shows its lower-level request one cycle after acceptance. The bench keeps `low_req_ready` low for one extra cycle to confirm the request is held. It then strobes the fill data and expects the answer, and `req_ready` high again, one cycle after that strobe. Expected ways, data and physical lines come from the bench's own modulo arithmetic, both for a table of requests on a 2-way cache and for a fully associative instance.

// File: rtl/sac_pkg.sv
package sac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_WAIT = 2'd2
  } sac_state_e;

  function automatic int unsigned sac_set_of(input int unsigned line, input int unsigned sets);
    return line % sets;
  endfunction

  function automatic int unsigned sac_tag_of(input int unsigned line, input int unsigned sets);
    return line / sets;
  endfunction

  function automatic int unsigned sac_phys_line(input int unsigned way, input int unsigned set,
                                                input int unsigned sets);
    return way * sets + set;
  endfunction

endpackage

// File: rtl/sac_tag_store.sv
module sac_tag_store #(
  parameter int NUM_LINES = 8,
  parameter int NUM_WAYS  = 2,
  parameter int SETS      = 4,
  parameter int SET_W     = 2,
  parameter int TAG_W     = 4,
  parameter int WAY_W     = 1,
  parameter int PHYS_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_W-1:0]    probe_set,
  input  logic [TAG_W-1:0]    probe_tag,
  output logic [NUM_WAYS-1:0] hit_vec,
  input  logic                wr_en,
  input  logic [WAY_W-1:0]    wr_way,
  input  logic [SET_W-1:0]    wr_set,
  input  logic [TAG_W-1:0]    wr_tag
);
  import sac_pkg::*;

  logic [NUM_LINES-1:0] valid_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];
  logic [PHYS_W-1:0]    wr_phys;

  assign wr_phys = PHYS_W'(sac_phys_line(32'(wr_way), 32'(wr_set), SETS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_phys] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_phys] <= wr_tag;
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way_probe
    logic [PHYS_W-1:0] probe_phys;
    assign probe_phys = PHYS_W'(sac_phys_line(w, 32'(probe_set), SETS));
    assign hit_vec[w] = valid_q[probe_phys] && (tag_q[probe_phys] == probe_tag);
  end

endmodule

// File: rtl/sac_data_store.sv
module sac_data_store #(
  parameter int NUM_LINES = 8,
  parameter int SETS      = 4,
  parameter int SET_W     = 2,
  parameter int WAY_W     = 1,
  parameter int PHYS_W    = 3,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [SET_W-1:0]  rd_set,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [DATA_W-1:0] wr_data
);
  import sac_pkg::*;

  logic [DATA_W-1:0] mem_q [NUM_LINES];
  logic [PHYS_W-1:0] rd_phys;
  logic [PHYS_W-1:0] wr_phys;

  assign rd_phys = PHYS_W'(sac_phys_line(32'(rd_way), 32'(rd_set), SETS));
  assign wr_phys = PHYS_W'(sac_phys_line(32'(wr_way), 32'(wr_set), SETS));
  assign rd_data = mem_q[rd_phys];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_phys] <= wr_data;
  end

endmodule

// File: rtl/sac_hit_encoder.sv
module sac_hit_encoder #(
  parameter int NUM_WAYS = 2,
  parameter int WAY_W    = 1
) (
  input  logic [NUM_WAYS-1:0] hit_vec,
  output logic                any_hit,
  output logic [WAY_W-1:0]    hit_way
);
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hit_vec[w]) hit_way = hit_way | WAY_W'(w);
    end
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/sac_lookup.sv
module sac_lookup #(
  parameter int LINE_W    = 6,
  parameter int NUM_LINES = 8,
  parameter int NUM_WAYS  = 2,
  parameter int DATA_W    = 8,
  localparam int SETS     = NUM_LINES / NUM_WAYS,
  localparam int SET_W    = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int TAG_W    = LINE_W - $clog2(SETS),
  localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int PHYS_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [LINE_W-1:0] req_line,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [SET_W-1:0]  vic_set,
  input  logic [WAY_W-1:0]  vic_way,
  output logic              low_req_valid,
  input  logic              low_req_ready,
  output logic [LINE_W-1:0] low_req_line,
  input  logic              low_rsp_valid,
  input  logic [DATA_W-1:0] low_rsp_data,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [PHYS_W-1:0] rsp_line,
  output logic [DATA_W-1:0] rsp_data
);
  import sac_pkg::*;

  sac_state_e        state_q;
  logic [LINE_W-1:0] mline_q;

  logic [LINE_W-1:0] cur_line;
  logic [SET_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;

  logic [NUM_WAYS-1:0] hit_vec;
  logic                lookup_hit;
  logic [WAY_W-1:0]    hit_way;
  logic [DATA_W-1:0]   rd_data;

  // named events
  logic accept;
  logic rd_hit;
  logic rd_miss;
  logic wr_hit;
  logic alloc_evt;
  logic fill_evt;

  logic              st_wr_en;
  logic [WAY_W-1:0]  st_way;
  logic [DATA_W-1:0] st_data;
  logic [WAY_W-1:0]  ans_way;
  logic [PHYS_W-1:0] ans_line;

  assign cur_line = (state_q == ST_IDLE) ? req_line : mline_q;
  assign cur_set  = SET_W'(sac_set_of(32'(cur_line), SETS));
  assign cur_tag  = TAG_W'(sac_tag_of(32'(cur_line), SETS));

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_hit    = accept && !req_write && lookup_hit;
  assign rd_miss   = accept && !req_write && !lookup_hit;
  assign wr_hit    = accept && req_write && lookup_hit;
  assign alloc_evt = accept && req_write && !lookup_hit;
  assign fill_evt  = (state_q == ST_WAIT) && low_rsp_valid;

  assign st_wr_en = wr_hit || alloc_evt || fill_evt;
  assign st_way   = wr_hit ? hit_way : vic_way;
  assign st_data  = fill_evt ? low_rsp_data : req_wdata;
  assign ans_way  = rd_hit ? hit_way : st_way;
  assign ans_line = PHYS_W'(sac_phys_line(32'(ans_way), 32'(cur_set), SETS));

  assign vic_set       = cur_set;
  assign low_req_valid = (state_q == ST_FWD);
  assign low_req_line  = mline_q;

  sac_tag_store #(
    .NUM_LINES(NUM_LINES), .NUM_WAYS(NUM_WAYS), .SETS(SETS), .SET_W(SET_W),
    .TAG_W(TAG_W), .WAY_W(WAY_W), .PHYS_W(PHYS_W)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .probe_set (cur_set),
    .probe_tag (cur_tag),
    .hit_vec   (hit_vec),
    .wr_en     (st_wr_en),
    .wr_way    (st_way),
    .wr_set    (cur_set),
    .wr_tag    (cur_tag)
  );

  sac_hit_encoder #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_enc (
    .hit_vec (hit_vec),
    .any_hit (lookup_hit),
    .hit_way (hit_way)
  );

  sac_data_store #(
    .NUM_LINES(NUM_LINES), .SETS(SETS), .SET_W(SET_W), .WAY_W(WAY_W),
    .PHYS_W(PHYS_W), .DATA_W(DATA_W)
  ) u_data (
    .clk     (clk),
    .rd_way  (hit_way),
    .rd_set  (cur_set),
    .rd_data (rd_data),
    .wr_en   (st_wr_en),
    .wr_way  (st_way),
    .wr_set  (cur_set),
    .wr_data (st_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mline_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (rd_miss) begin
          state_q <= ST_FWD;
          mline_q <= req_line;
        end
        ST_FWD:  if (low_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (low_rsp_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_write <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_line  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_hit || st_wr_en;
      if (rd_hit || st_wr_en) begin
        rsp_write <= accept && req_write;
        rsp_hit   <= rd_hit || wr_hit;
        rsp_way   <= ans_way;
        rsp_line  <= ans_line;
        rsp_data  <= rd_hit ? rd_data : st_data;
      end
    end
  end

endmodule

// File: rtl/sac_lookup_checker.sv
module sac_lookup_checker #(
  parameter int NUM_WAYS = 2,
  parameter int LINE_W   = 6,
  parameter int WAY_W    = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic                low_req_valid,
  input logic                low_req_ready,
  input logic [LINE_W-1:0]   low_req_line,
  input logic                rsp_valid,
  input logic                rsp_write,
  input logic                rsp_hit,
  input logic [NUM_WAYS-1:0] hit_vec,
  input logic                rd_hit,
  input logic                alloc_evt,
  input logic                fill_evt,
  input logic [WAY_W-1:0]    vic_way
);

  // R3: never more than one way hits
  assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R4: a read hit answers as a hit one cycle later
  assert_read_hit_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (rsp_valid && rsp_hit && !rsp_write));

  // R5: the forwarded request is held until taken
  assert_low_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_req_valid && !low_req_ready) |=> (low_req_valid && $stable(low_req_line)));

  // R5: a fill answers as a miss one cycle later
  assert_fill_answer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (rsp_valid && !rsp_hit && !rsp_write));

  // R6: a forwarded request only follows an accepted read
  assert_forward_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_req_valid) |-> $past(req_valid && req_ready && !req_write));

  // R8: a write miss answers as a miss one cycle later
  assert_alloc_answer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_evt |=> (rsp_valid && !rsp_hit && rsp_write));

  // R8: victim selector stays within the ways
  assert_victim_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_evt || fill_evt) |-> (32'(vic_way) < NUM_WAYS));

endmodule

bind sac_lookup sac_lookup_checker #(
  .NUM_WAYS(NUM_WAYS), .LINE_W(LINE_W), .WAY_W(WAY_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .low_req_valid (low_req_valid),
  .low_req_ready (low_req_ready),
  .low_req_line  (low_req_line),
  .rsp_valid     (rsp_valid),
  .rsp_write     (rsp_write),
  .rsp_hit       (rsp_hit),
  .hit_vec       (hit_vec),
  .rd_hit        (rd_hit),
  .alloc_evt     (alloc_evt),
  .fill_evt      (fill_evt),
  .vic_way       (vic_way)
);

// File: tb/sac_lookup_bench.sv
module sac_lookup_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // 2-way, 8-line instance
  logic       req_valid = 0, req_write = 0;
  logic [5:0] req_line = '0;
  logic [7:0] req_wdata = '0;
  logic       vic_way = 0;
  logic       req_ready;
  logic [1:0] vic_set;
  logic       low_req_valid;
  logic       low_req_ready = 0;
  logic [5:0] low_req_line;
  logic       low_rsp_valid = 0;
  logic [7:0] low_rsp_data = '0;
  logic       rsp_valid, rsp_write, rsp_hit, rsp_way;
  logic [2:0] rsp_line;
  logic [7:0] rsp_data;

  sac_lookup u_sac_lookup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_line(req_line), .req_wdata(req_wdata),
    .vic_set(vic_set), .vic_way(vic_way), .low_req_valid(low_req_valid),
    .low_req_ready(low_req_ready), .low_req_line(low_req_line),
    .low_rsp_valid(low_rsp_valid), .low_rsp_data(low_rsp_data),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_line(rsp_line), .rsp_data(rsp_data)
  );

  // fully associative instance (8 ways, one set)
  logic       f_req_valid = 0, f_req_write = 0;
  logic [5:0] f_req_line = '0;
  logic [7:0] f_req_wdata = '0;
  logic [2:0] f_vic_way = '0;
  logic       f_req_ready;
  logic [0:0] f_vic_set;
  logic       f_low_req_valid;
  logic       f_low_req_ready = 1'b1;
  logic [5:0] f_low_req_line;
  logic       f_low_rsp_valid = 1'b0;
  logic [7:0] f_low_rsp_data = '0;
  logic       f_rsp_valid, f_rsp_write, f_rsp_hit;
  logic [2:0] f_rsp_way;
  logic [2:0] f_rsp_line;
  logic [7:0] f_rsp_data;

  sac_lookup #(.NUM_WAYS(8)) u_sac_lookup_full (
    .clk(clk), .rst_n(rst_n), .req_valid(f_req_valid), .req_ready(f_req_ready),
    .req_write(f_req_write), .req_line(f_req_line), .req_wdata(f_req_wdata),
    .vic_set(f_vic_set), .vic_way(f_vic_way), .low_req_valid(f_low_req_valid),
    .low_req_ready(f_low_req_ready), .low_req_line(f_low_req_line),
    .low_rsp_valid(f_low_rsp_valid), .low_rsp_data(f_low_rsp_data),
    .rsp_valid(f_rsp_valid), .rsp_write(f_rsp_write), .rsp_hit(f_rsp_hit),
    .rsp_way(f_rsp_way), .rsp_line(f_rsp_line), .rsp_data(f_rsp_data)
  );

  // {write, line, wdata, victim, exp_hit, exp_way, exp_data}
  localparam int NV = 16;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 6'd9,  8'h11, 1'b0, 1'b0, 1'b0, 8'h11},
    {1'b0, 6'd9,  8'h00, 1'b0, 1'b1, 1'b0, 8'h11},
    {1'b1, 6'd13, 8'h22, 1'b1, 1'b0, 1'b1, 8'h22},
    {1'b0, 6'd13, 8'h00, 1'b0, 1'b1, 1'b1, 8'h22},
    {1'b0, 6'd9,  8'h00, 1'b0, 1'b1, 1'b0, 8'h11},
    {1'b1, 6'd9,  8'h33, 1'b1, 1'b1, 1'b0, 8'h33},
    {1'b0, 6'd9,  8'h00, 1'b1, 1'b1, 1'b0, 8'h33},
    {1'b0, 6'd5,  8'h00, 1'b1, 1'b0, 1'b1, 8'hA0},
    {1'b0, 6'd13, 8'h00, 1'b0, 1'b0, 1'b0, 8'hA8},
    {1'b0, 6'd5,  8'h00, 1'b0, 1'b1, 1'b1, 8'hA0},
    {1'b0, 6'd2,  8'h00, 1'b0, 1'b0, 1'b0, 8'hA7},
    {1'b0, 6'd2,  8'h00, 1'b1, 1'b1, 1'b0, 8'hA7},
    {1'b1, 6'd63, 8'h5A, 1'b1, 1'b0, 1'b1, 8'h5A},
    {1'b0, 6'd63, 8'h00, 1'b0, 1'b1, 1'b1, 8'h5A},
    {1'b0, 6'd0,  8'h00, 1'b1, 1'b0, 1'b1, 8'hA5},
    {1'b0, 6'd0,  8'h00, 1'b0, 1'b1, 1'b1, 8'hA5}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic wr, input logic [5:0] line, input logic [7:0] wd,
                       input logic vic, input logic exp_hit, input logic exp_way,
                       input logic [7:0] exp_data);
    string rq;
    logic [2:0] exp_phys;
    rq = wr ? (exp_hit ? "R7" : "R8") : (exp_hit ? "R4" : "R5");
    exp_phys = 3'(32'(exp_way) * 4 + 32'(line) % 4);  // R1 R2: way*SETS + line mod SETS
    @(negedge clk);
    req_valid = 1; req_write = wr; req_line = line; req_wdata = wd; vic_way = vic;
    @(negedge clk);
    req_valid = 0;
    if (!wr && !exp_hit) begin
      chk("R6", "req_ready during miss", 32'(req_ready), 0);
      chk("R5", "low_req_valid", 32'(low_req_valid), 1);
      chk("R5", "low_req_line", 32'(low_req_line), 32'(line));
      @(negedge clk);
      chk("R5", "low_req_valid held", 32'(low_req_valid), 1);
      low_req_ready = 1;
      @(negedge clk);
      low_req_ready = 0;
      chk("R5", "low_req_valid dropped", 32'(low_req_valid), 0);
      chk("R6", "req_ready waiting", 32'(req_ready), 0);
      low_rsp_valid = 1; low_rsp_data = {2'b00, line} ^ 8'hA5;
      @(negedge clk);
      low_rsp_valid = 0;
      chk("R6", "req_ready after fill", 32'(req_ready), 1);
    end else begin
      chk(rq, "no lower request", 32'(low_req_valid), 0);
    end
    chk(rq, "rsp_valid", 32'(rsp_valid), 1);
    chk(rq, "rsp_write", 32'(rsp_write), 32'(wr));
    chk(rq, "rsp_hit", 32'(rsp_hit), 32'(exp_hit));
    chk(rq, "rsp_way", 32'(rsp_way), 32'(exp_way));
    chk("R2", "rsp_line", 32'(rsp_line), 32'(exp_phys));
    chk(rq, "rsp_data", 32'(rsp_data), 32'(exp_data));
  endtask

  task automatic fa_op(input logic wr, input logic [5:0] line, input logic [7:0] wd,
                       input logic [2:0] vic, input logic exp_hit, input logic [2:0] exp_way,
                       input logic [7:0] exp_data);
    @(negedge clk);
    f_req_valid = 1; f_req_write = wr; f_req_line = line; f_req_wdata = wd; f_vic_way = vic;
    @(negedge clk);
    f_req_valid = 0;
    chk("R10", "full rsp_valid", 32'(f_rsp_valid), 1);
    chk("R10", "full rsp_hit", 32'(f_rsp_hit), 32'(exp_hit));
    chk("R10", "full rsp_way", 32'(f_rsp_way), 32'(exp_way));
    chk("R10", "full rsp_line", 32'(f_rsp_line), 32'(exp_way));
    chk("R10", "full rsp_data", 32'(f_rsp_data), 32'(exp_data));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9", "req_ready after reset", 32'(req_ready), 1);
    chk("R9", "rsp_valid after reset", 32'(rsp_valid), 0);
    chk("R9", "low_req_valid after reset", 32'(low_req_valid), 0);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][25], VEC[i][24:19], VEC[i][18:11], VEC[i][10], VEC[i][9],
            VEC[i][8], VEC[i][7:0]);
    end

    // R10: four lines that share a set under 2 ways all coexist
    fa_op(1, 6'd1,  8'h61, 3'd0, 0, 3'd0, 8'h61);
    fa_op(1, 6'd9,  8'h69, 3'd1, 0, 3'd1, 8'h69);
    fa_op(1, 6'd17, 8'h71, 3'd2, 0, 3'd2, 8'h71);
    fa_op(1, 6'd25, 8'h79, 3'd3, 0, 3'd3, 8'h79);
    fa_op(0, 6'd1,  8'h00, 3'd7, 1, 3'd0, 8'h61);
    fa_op(0, 6'd9,  8'h00, 3'd7, 1, 3'd1, 8'h69);
    fa_op(0, 6'd17, 8'h00, 3'd7, 1, 3'd2, 8'h71);
    fa_op(0, 6'd25, 8'h00, 3'd7, 1, 3'd3, 8'h79);

    // R9: reset mid-run drops every line
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9", "req_ready after reset", 32'(req_ready), 1);
    chk("R9", "rsp_valid after reset", 32'(rsp_valid), 0);
    do_op(0, 6'd9, 8'h00, 1'b0, 1'b0, 1'b0, 8'hAC);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule